// File: doc/BRIEF.md
# Two-Register Serial Control Slave for a Digital Potentiometer

This block is the two-wire serial slave front end of a digitally controlled potentiometer. It watches the serial clock and data lines with the chip's own system clock and recognises frame boundaries (START, repeated START, STOP). It accepts a seven-bit identification byte whose two low bits are taken from two board-strapped pins, so up to four such devices can share one bus. It pulls the data line low, and never high, to acknowledge and to return read data.

Two registers sit behind it. The wiper position register is at address 00h and drives the analog tap selector. The control register is at address 10h and holds a single enable bit for the resistor array. A host writes by sending the identification byte, a register address and one data byte. It reads by sending the identification byte and an address, then a repeated START and the identification byte with the read flag set. The slave then streams the addressed register until the host declines a byte.

Top module: `tapctl_i2c`

## Requirements
- R1: After reset the wiper register holds 40h, the control enable bit is 1 (the control register reads 40h), `active_o` is 1, and `sda_pull_o` is 0.
- R2: The identification byte is accepted only when bits [7:3] equal 10100 and bits [2:1] equal `strap_i`. Bit 0 is the transfer direction (1 = read, 0 = write). A mismatching byte gets no ACK, and the remaining bytes of that frame get no ACK and change nothing until the next START.
- R3: A write frame is START, identification byte with bit 0 = 0, register address, one data byte, STOP, and the slave ACKs all three bytes. The register changes at the rising SCL edge of the ninth clock of the data byte and not before it.
- R4: The wiper register at address 00h keeps bits [6:0] of the written byte and drives them on `wiper_o`. A read returns it with bit 7 = 0.
- R5: The control register at address 10h keeps only bit 6 of a written byte and drives it on `active_o`. A read returns bit 6 with all other bits 0. A write to it leaves the wiper register unchanged.
- R6: An address byte other than 00h or 10h gets no ACK and leaves both registers unchanged. A following repeated START with a read identification byte also gets no ACK.
- R7: Data driven by the slave goes out MSB first and changes only while SCL is low, so it is stable through every SCL high phase.
- R8: A read frame is START, identification byte (write), address, repeated START, identification byte (read), and the slave ACKs all three. Each data byte that follows returns the same addressed register. A host ACK requests another byte. A host NACK ends the transfer, and the slave releases SDA.
- R9: A read identification byte gets no ACK unless an address byte has been accepted since the last STOP.
- R10: Bus activity before the first START is ignored. A STOP returns the slave to idle with SDA released. A START at any point restarts the frame at the identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level seen on the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| strap_i | input | 2 | Strapped low bits of the identification byte |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| wiper_o | output | 7 | Current wiper tap position |
| active_o | output | 1 | Control enable bit (0 = array shut down) |

## Verification
The bench offers every one of the 128 identification codes and checks that exactly one is acknowledged. A slave that decoded the strap bits or the device code loosely would answer for a neighbour on the bus. It watches the wiper output through the ACK clock of each data byte in a sweep of written values. A slave that committed on the eighth clock would show the new value one edge early, and one that dropped bit 6 would read back wrong. It issues reads with no address phase, reads after a rejected address, and a repeated START in the middle of a write. A slave that did not clear its read permission at STOP, or that did not restart on a repeated START, would acknowledge or write where it must not. It also streams several read bytes and releases on a host NACK. A slave that advanced the address, or kept holding SDA after the NACK, would corrupt the data or hang the bus.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

  // Frame progress of the serial slave.
  typedef enum logic [3:0] {
    S_IDLE,
    S_ID,
    S_ID_ACK,
    S_ADR,
    S_ADR_ACK,
    S_WR,
    S_WR_ACK,
    S_TX,
    S_TX_ACK
  } bus_state_t;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int STRAP_W = 2;
  localparam int CODE_W = BYTE_W - STRAP_W - 1;

endpackage

// File: rtl/tapctl_line_sync.sv
module tapctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prv;

  assign raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES:0] chain_q;
      logic [STAGES:0] chain_n;

      assign chain_n = {chain_q[STAGES-1:0], raw[g]};

      // Idle bus level is high on both wires.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= chain_n;
        end
      end

      assign cur[g] = chain_q[STAGES-1];
      assign prv[g] = chain_q[STAGES];
    end
  endgenerate

  assign scl_lvl_o  = cur[SCL_IX];
  assign sda_lvl_o  = cur[SDA_IX];
  assign scl_rise_o = cur[SCL_IX] & ~prv[SCL_IX];
  assign scl_fall_o = ~cur[SCL_IX] & prv[SCL_IX];
  assign start_o    = cur[SCL_IX] & prv[SCL_IX] & prv[SDA_IX] & ~cur[SDA_IX];
  assign stop_o     = cur[SCL_IX] & prv[SCL_IX] & ~prv[SDA_IX] & cur[SDA_IX];

endmodule

// File: rtl/tapctl_regs.sv
module tapctl_regs #(
  parameter int         WIPER_W   = 7,
  parameter int         WIPER_RST = 64,
  parameter logic [7:0] WIPER_ADR = 8'h00,
  parameter logic [7:0] CTL_ADR   = 8'h10,
  parameter int         CTL_BIT   = 6,
  parameter logic       CTL_RST   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         addr_i,
  input  logic [WIPER_W-1:0] wdata_i,
  input  logic               we_i,
  output logic               hit_o,
  output logic [7:0]         rdata_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               ctl_o
);

  logic [WIPER_W-1:0] wiper_q, wiper_n;
  logic               ctl_q, ctl_n;
  logic               sel_wiper, sel_ctl;

  assign sel_wiper = (addr_i == WIPER_ADR);
  assign sel_ctl   = (addr_i == CTL_ADR);

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    if (sel_wiper) begin
      hit_o                  = 1'b1;
      rdata_o[WIPER_W-1:0]   = wiper_q;
    end else if (sel_ctl) begin
      hit_o                  = 1'b1;
      rdata_o[CTL_BIT]       = ctl_q;
    end
  end

  always_comb begin
    wiper_n = wiper_q;
    ctl_n   = ctl_q;
    if (we_i && sel_wiper) begin
      wiper_n = wdata_i;
    end
    if (we_i && sel_ctl) begin
      ctl_n = wdata_i[CTL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= WIPER_W'(WIPER_RST);
      ctl_q   <= CTL_RST;
    end else begin
      wiper_q <= wiper_n;
      ctl_q   <= ctl_n;
    end
  end

  assign wiper_o = wiper_q;
  assign ctl_o   = ctl_q;

  // R3
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(wiper_o) && $stable(ctl_o)));

  // R4
  wiper_takes_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == WIPER_ADR) |=> (wiper_o == $past(wdata_i)));

endmodule

// File: rtl/tapctl_bus_fsm.sv
module tapctl_bus_fsm
  import tapctl_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 5'b10100,
  parameter int                WDATA_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_lvl_i,
  input  logic               sda_lvl_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               hit_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic [BYTE_W-1:0]  addr_o,
  output logic [WDATA_W-1:0] wdata_o,
  output logic               we_o,
  output logic               sda_low_o
);

  bus_state_t           state_q, state_n;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_n;
  logic [BYTE_W-1:0]    sh_q, sh_n;
  logic [BYTE_W-1:0]    adr_q, adr_n;
  logic                 full_q, full_n;
  logic                 sda_q, sda_n;
  logic                 rd_ok_q, rd_ok_n;
  logic                 more_q, more_n;
  logic                 id_match;
  logic                 rx_state;

  assign rx_state = (state_q == S_ID) || (state_q == S_ADR) || (state_q == S_WR);
  assign id_match = (sh_q[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                    (sh_q[STRAP_W:1] == strap_i) &&
                    (!sh_q[0] || rd_ok_q);

  // During the address byte the register file decodes the byte being shifted.
  assign addr_o    = (state_q == S_ADR) ? sh_q : adr_q;
  assign wdata_o   = sh_q[WDATA_W-1:0];
  assign we_o      = (state_q == S_WR_ACK) && scl_rise_i && !start_i && !stop_i;
  assign sda_low_o = sda_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    adr_n   = adr_q;
    full_n  = full_q;
    sda_n   = sda_q;
    rd_ok_n = rd_ok_q;
    more_n  = more_q;
    if (stop_i) begin
      state_n = S_IDLE;
      sda_n   = 1'b0;
      full_n  = 1'b0;
      cnt_n   = '0;
      rd_ok_n = 1'b0;
    end else if (start_i) begin
      state_n = S_ID;
      sda_n   = 1'b0;
      full_n  = 1'b0;
      cnt_n   = '0;
    end else if (rx_state) begin
      if (scl_rise_i && !full_q) begin
        sh_n   = {sh_q[BYTE_W-2:0], sda_lvl_i};
        cnt_n  = cnt_q + 1'b1;
        full_n = (cnt_q == BIT_CNT_W'(BYTE_W - 1));
      end else if (scl_fall_i && full_q) begin
        full_n = 1'b0;
        cnt_n  = '0;
        case (state_q)
          S_ID: begin
            if (id_match) begin
              sda_n   = 1'b1;
              state_n = S_ID_ACK;
            end else begin
              state_n = S_IDLE;
            end
          end
          S_ADR: begin
            adr_n = sh_q;
            if (hit_i) begin
              sda_n   = 1'b1;
              rd_ok_n = 1'b1;
              state_n = S_ADR_ACK;
            end else begin
              rd_ok_n = 1'b0;
              state_n = S_IDLE;
            end
          end
          default: begin
            sda_n   = 1'b1;
            state_n = S_WR_ACK;
          end
        endcase
      end
    end else begin
      case (state_q)
        S_ID_ACK: begin
          if (scl_fall_i) begin
            if (sh_q[0]) begin
              sh_n    = rdata_i;
              sda_n   = ~rdata_i[BYTE_W-1];
              cnt_n   = '0;
              state_n = S_TX;
            end else begin
              sda_n   = 1'b0;
              state_n = S_ADR;
            end
          end
        end
        S_ADR_ACK: begin
          if (scl_fall_i) begin
            sda_n   = 1'b0;
            state_n = S_WR;
          end
        end
        S_WR_ACK: begin
          if (scl_fall_i) begin
            sda_n   = 1'b0;
            state_n = S_IDLE;
          end
        end
        S_TX: begin
          if (scl_rise_i && !full_q) begin
            cnt_n  = cnt_q + 1'b1;
            full_n = (cnt_q == BIT_CNT_W'(BYTE_W - 1));
          end else if (scl_fall_i) begin
            if (full_q) begin
              full_n  = 1'b0;
              sda_n   = 1'b0;
              state_n = S_TX_ACK;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              sda_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_rise_i) begin
            more_n = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (more_q) begin
              sh_n    = rdata_i;
              sda_n   = ~rdata_i[BYTE_W-1];
              cnt_n   = '0;
              state_n = S_TX;
            end else begin
              sda_n   = 1'b0;
              state_n = S_IDLE;
            end
          end
        end
        default: begin
          state_n = S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      adr_q   <= '0;
      full_q  <= 1'b0;
      sda_q   <= 1'b0;
      rd_ok_q <= 1'b0;
      more_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      adr_q   <= adr_n;
      full_q  <= full_n;
      sda_q   <= sda_n;
      rd_ok_q <= rd_ok_n;
      more_q  <= more_n;
    end
  end

  // R10
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !sda_low_o);

  // R7
  drive_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> !scl_lvl_i);

  // R2
  idle_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !sda_low_o);

endmodule

// File: rtl/tapctl_i2c.sv
module tapctl_i2c
  import tapctl_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] DEV_CODE    = 5'b10100,
  parameter int                WIPER_W     = 7,
  parameter int                WIPER_RST   = 64,
  parameter logic [7:0]        WIPER_ADR   = 8'h00,
  parameter logic [7:0]        CTL_ADR     = 8'h10,
  parameter int                CTL_BIT     = 6,
  parameter logic              CTL_RST     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               active_o
);

  logic               scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic               hit, we;
  logic [BYTE_W-1:0]  rdata, addr;
  logic [WIPER_W-1:0] wdata;

  tapctl_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl_o (scl_lvl),
    .sda_lvl_o (sda_lvl),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  tapctl_bus_fsm #(
    .DEV_CODE(DEV_CODE),
    .WDATA_W (WIPER_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl_i (scl_lvl),
    .sda_lvl_i (sda_lvl),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .strap_i   (strap_i),
    .hit_i     (hit),
    .rdata_i   (rdata),
    .addr_o    (addr),
    .wdata_o   (wdata),
    .we_o      (we),
    .sda_low_o (sda_pull_o)
  );

  tapctl_regs #(
    .WIPER_W  (WIPER_W),
    .WIPER_RST(WIPER_RST),
    .WIPER_ADR(WIPER_ADR),
    .CTL_ADR  (CTL_ADR),
    .CTL_BIT  (CTL_BIT),
    .CTL_RST  (CTL_RST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .hit_o  (hit),
    .rdata_o(rdata),
    .wiper_o(wiper_o),
    .ctl_o  (active_o)
  );

endmodule

// File: tb/sim_tapctl_i2c.sv
module sim_tapctl_i2c;

  localparam int Q = 4;
  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic       sda_pull;
  logic [6:0] wiper;
  logic       active;
  logic       sda_bus;

  int vecs = 0;
  int bad = 0;
  int unstable = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull;

  tapctl_i2c u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .strap_i   (strap),
    .sda_pull_o(sda_pull),
    .wiper_o   (wiper),
    .active_o  (active)
  );

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    q(); m_sda = 1'b1;
    q(); m_scl = 1'b1;
    q(); m_sda = 1'b0;
    q(); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    q(); m_sda = 1'b0;
    q(); m_scl = 1'b1;
    q(); m_sda = 1'b1;
    q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack,
                           output logic [6:0] pre, output logic [6:0] post);
    for (int i = 7; i >= 0; i--) begin
      q(); m_sda = b[i];
      q(); m_scl = 1'b1;
      q(); q(); m_scl = 1'b0;
    end
    q(); m_sda = 1'b1;
    q(); pre = wiper; m_scl = 1'b1;
    q(); q(); ack = !sda_bus; post = wiper; m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); m_sda = 1'b1;
      q(); m_scl = 1'b1;
      q(); s = sda_bus; b = {b[6:0], sda_bus};
      q(); if (sda_bus !== s) unstable++;
      m_scl = 1'b0;
    end
    q(); m_sda = !mack;
    q(); m_scl = 1'b1;
    q(); q(); m_scl = 1'b0;
  endtask

  function automatic logic [7:0] id_byte(input bit rd);
    return {5'b10100, strap, rd};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output bit [2:0] acks,
                    output logic [6:0] pre, output logic [6:0] post);
    logic [6:0] x0, x1;
    bus_start();
    send_byte(id_byte(1'b0), acks[2], x0, x1);
    send_byte(a, acks[1], x0, x1);
    send_byte(d, acks[0], pre, post);
    bus_stop();
  endtask

  task automatic rd(input logic [7:0] a, output bit [2:0] acks, output logic [7:0] v);
    logic [6:0] x0, x1;
    bus_start();
    send_byte(id_byte(1'b0), acks[2], x0, x1);
    send_byte(a, acks[1], x0, x1);
    bus_start();
    send_byte(id_byte(1'b1), acks[0], x0, x1);
    recv_byte(1'b0, v);
    bus_stop();
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      bad++;
      vecs++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    bit [2:0]   acks;
    bit         ack;
    logic [6:0] pre, post, prev, keep_w;
    logic [7:0] v, d;
    logic       keep_a;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 wiper", wiper, 8'h40);
    chk("R1 active", active, 1);
    chk("R1 sda", sda_pull, 0);

    // R10 bytes clocked before any START are ignored
    send_byte(id_byte(1'b0), ack, pre, post);
    chk("R10 no ack before start", ack, 0);
    send_byte(8'h00, ack, pre, post);
    send_byte(8'h11, ack, pre, post);
    chk("R10 no write before start", wiper, 8'h40);
    bus_stop();

    // R1 reset values read back over the bus
    rd(8'h00, acks, v);
    chk("R1 wiper read acks", acks, 7);
    chk("R1 wiper read", v, 8'h40);
    rd(8'h10, acks, v);
    chk("R1 ctl read", v, 8'h40);

    // R2 sweep of every identification code with strap 01
    for (int id = 0; id < 128; id++) begin
      bus_start();
      send_byte({id[6:0], 1'b0}, ack, pre, post);
      chk("R2 id sweep", ack, (id[6:0] == {5'b10100, strap}) ? 1 : 0);
      bus_stop();
    end

    // R2 every strap value, matching and mismatching
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      d = 8'h10 + 8'(s);
      wr(8'h00, d, acks, pre, post);
      chk("R2 strap write acks", acks, 7);
      chk("R2 strap write", wiper, d[6:0]);
      bus_start();
      send_byte({5'b10100, strap ^ 2'b01, 1'b0}, ack, pre, post);
      chk("R2 wrong strap", ack, 0);
      send_byte(8'h00, ack, pre, post);
      chk("R2 ignored addr", ack, 0);
      send_byte(8'h7a, ack, pre, post);
      chk("R2 ignored data", ack, 0);
      bus_stop();
      chk("R2 no write", wiper, d[6:0]);
    end
    strap = 2'b01;

    // R3 / R4 wiper sweep with commit timing
    prev = wiper;
    for (int k = 0; k < 52; k++) begin
      d = 8'(k * 5);
      wr(8'h00, d, acks, pre, post);
      chk("R3 write acks", acks, 7);
      chk("R3 unchanged before ninth clock", pre, prev);
      chk("R3 committed at ninth clock", post, d[6:0]);
      rd(8'h00, acks, v);
      chk("R4 readback low bits", v, {1'b0, d[6:0]});
      prev = d[6:0];
    end

    // R5 control register sweep
    for (int k = 0; k < 16; k++) begin
      d = 8'(k * 17);
      keep_w = wiper;
      wr(8'h10, d, acks, pre, post);
      chk("R5 write acks", acks, 7);
      chk("R5 active bit", active, d[6]);
      rd(8'h10, acks, v);
      chk("R5 readback", v, {1'b0, d[6], 6'b0});
      chk("R5 wiper untouched", wiper, keep_w);
    end

    // R6 unmapped addresses
    foreach (v[i]) begin end
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: d = 8'h01;
        1: d = 8'h0f;
        2: d = 8'h11;
        3: d = 8'h20;
        4: d = 8'h80;
        default: d = 8'hff;
      endcase
      keep_w = wiper;
      keep_a = active;
      bus_start();
      send_byte(id_byte(1'b0), ack, pre, post);
      chk("R6 id ack", ack, 1);
      send_byte(d, ack, pre, post);
      chk("R6 unmapped nack", ack, 0);
      send_byte(8'h00, ack, pre, post);
      chk("R6 data ignored", ack, 0);
      bus_stop();
      chk("R6 wiper kept", wiper, keep_w);
      chk("R6 active kept", active, keep_a);
      bus_start();
      send_byte(id_byte(1'b0), ack, pre, post);
      send_byte(d, ack, pre, post);
      bus_start();
      send_byte(id_byte(1'b1), ack, pre, post);
      chk("R6 read after bad addr nack", ack, 0);
      bus_stop();
    end

    // R8 burst read returns the same register
    wr(8'h00, 8'h5a, acks, pre, post);
    bus_start();
    send_byte(id_byte(1'b0), acks[2], pre, post);
    send_byte(8'h00, acks[1], pre, post);
    bus_start();
    send_byte(id_byte(1'b1), acks[0], pre, post);
    chk("R8 read acks", acks, 7);
    for (int n = 0; n < 4; n++) begin
      recv_byte(n < 3, v);
      chk("R8 repeat byte", v, 8'h5a);
    end
    q();
    chk("R8 released after nack", sda_pull, 0);
    bus_stop();
    // R7 no slave data changed during SCL high
    chk("R7 stable while high", unstable, 0);

    // R9 read without address phase
    bus_start();
    send_byte(id_byte(1'b1), ack, pre, post);
    chk("R9 read without address", ack, 0);
    bus_stop();
    bus_start();
    send_byte(id_byte(1'b0), ack, pre, post);
    send_byte(8'h00, ack, pre, post);
    chk("R9 address ack", ack, 1);
    bus_stop();
    bus_start();
    send_byte(id_byte(1'b1), ack, pre, post);
    chk("R9 stop clears address", ack, 0);
    bus_stop();

    // R10 repeated START inside a write redirects the frame
    bus_start();
    send_byte(id_byte(1'b0), ack, pre, post);
    send_byte(8'h00, ack, pre, post);
    bus_start();
    send_byte(id_byte(1'b0), acks[2], pre, post);
    send_byte(8'h10, acks[1], pre, post);
    send_byte(8'h00, acks[0], pre, post);
    chk("R10 restart acks", acks, 7);
    bus_stop();
    chk("R10 restart wrote ctl", active, 0);
    chk("R10 wiper not written", wiper, 7'h5a);
    chk("R10 idle after stop", sda_pull, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule